// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the device-side control logic of a byte-wide flash memory. Bus write cycles reach it as an address/data pair with a one-cycle write strobe. A small state machine checks each write against the expected unlock step. After the two-write unlock prefix, a command byte written at the first unlock address selects one of four operations: byte program, identify, return to read, or the erase setup. The erase setup needs a second unlock prefix, followed by either a chip erase or a sector erase that names the sector by its address. Any write that is out of step drops the partial sequence, and the device goes back to normal reads. No separate reset command exists.

The storage is a behavioural byte array split into equal sectors, and parameters set its size. Programming can only clear bits. Erasing fills a sector, or the whole array, with FFh. A program or erase starts a busy countdown whose length is set by a parameter. While the countdown runs, every bus write is ignored and every read returns FFh. The read port is registered. When the identify mode is active, it returns the two identification bytes in place of array data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy` is low, the block is in normal read mode, and every array byte reads FFh.
- R2: In normal read mode with `busy` low, `rd_data` presents, one clock after `rd_addr` is sampled, the byte indexed by the low `SECT_LOG2+NSECT_LOG2` bits of `rd_addr`. Upper address bits alias.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by one write D@A program the byte at A. The new contents are the old contents AND D, so programming never sets a bit.
- R4: `busy` rises on the clock after the final write of a program, sector erase or chip erase sequence. It stays high for exactly `PROG_CYC`, `SERASE_CYC` or `CERASE_CYC` cycles respectively.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@SA set every byte of the sector selected by address bits [SECT_LOG2+NSECT_LOG2-1:SECT_LOG2] of SA to FFh. No other sector changes.
- R6: The same erase prefix ended by 10h@5555h sets every array byte to FFh.
- R7: The prefix followed by 90h@5555h enters identify mode. In that mode a read whose low eight address bits are 00h returns 40h, 01h returns 82h, and any other offset returns 00h.
- R8: Identify mode ends on a single write of F0h to any address, and also on the prefix followed by F0h@5555h. Reads then return array data.
- R9: A write that does not match the expected step discards the partial sequence and leaves identify mode. A later lone address/data write programs nothing.
- R10: Writes issued while `busy` is high are ignored. They neither advance a sequence nor change the array.
- R11: While `busy` is high, a read returns FFh.
- R12: Unlock and command address matching compares only `wr_addr[14:0]`. Higher address bits may hold any value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle pulse marking a bus write cycle |
| wr_addr | input | ADDR_W | Address of the bus write |
| wr_data | input | 8 | Data of the bus write |
| rd_addr | input | ADDR_W | Read address, sampled every clock |
| rd_data | output | 8 | Registered read data (array, ID byte, or FFh while busy) |
| busy | output | 1 | Internal program or erase in progress |

## Verification
The bench builds the block with an 18-bit address, 8-byte sectors and 4 sectors, which gives a 32-byte array. The busy lengths are 5, 12 and 20 cycles. This small array lets every byte be swept after each operation, so a sector erase is checked against all of its neighbours and the whole array is checked after a chip erase. The short busy windows let the exact busy length be counted, and they leave enough room to issue a complete program sequence and a read while an erase is still running.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int UNLOCK_W = 15;
   localparam logic [UNLOCK_W-1:0] ADR_FIRST  = 15'h5555;
   localparam logic [UNLOCK_W-1:0] ADR_SECOND = 15'h2AAA;

   localparam logic [7:0] DAT_UNLOCK1  = 8'hAA;
   localparam logic [7:0] DAT_UNLOCK2  = 8'h55;
   localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
   localparam logic [7:0] CMD_IDENTIFY = 8'h90;
   localparam logic [7:0] CMD_TO_READ  = 8'hF0;
   localparam logic [7:0] CMD_ERS_SET  = 8'h80;
   localparam logic [7:0] CMD_ERS_CHIP = 8'h10;
   localparam logic [7:0] CMD_ERS_SECT = 8'h30;
   localparam logic [7:0] ERASED_BYTE  = 8'hFF;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_UNL1,
      SQ_UNL2,
      SQ_PROG,
      SQ_XUNL0,
      SQ_XUNL1,
      SQ_XCMD
   } seq_state_t;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_PROG,
      OP_SECT,
      OP_CHIP
   } op_t;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output op_t               op_o,
   output logic              ident_o,
   output seq_state_t        state_o
);

   seq_state_t state_q, state_d;
   logic       ident_q, ident_d;
   logic       at_first, at_second;

   assign at_first  = (wr_addr[UNLOCK_W-1:0] == ADR_FIRST);
   assign at_second = (wr_addr[UNLOCK_W-1:0] == ADR_SECOND);

   always_comb begin
      state_d = state_q;
      ident_d = ident_q;
      op_o    = OP_NONE;
      if (wr_en) begin
         state_d = SQ_IDLE;
         unique case (state_q)
            SQ_IDLE: begin
               if (at_first && wr_data == DAT_UNLOCK1) state_d = SQ_UNL1;
            end
            SQ_UNL1: begin
               if (at_second && wr_data == DAT_UNLOCK2) state_d = SQ_UNL2;
            end
            SQ_UNL2: begin
               if (at_first) begin
                  if (wr_data == CMD_PROGRAM)      state_d = SQ_PROG;
                  else if (wr_data == CMD_ERS_SET) state_d = SQ_XUNL0;
               end
            end
            SQ_PROG: begin
               op_o = OP_PROG;
            end
            SQ_XUNL0: begin
               if (at_first && wr_data == DAT_UNLOCK1) state_d = SQ_XUNL1;
            end
            SQ_XUNL1: begin
               if (at_second && wr_data == DAT_UNLOCK2) state_d = SQ_XCMD;
            end
            SQ_XCMD: begin
               if (wr_data == CMD_ERS_SECT)                  op_o = OP_SECT;
               else if (at_first && wr_data == CMD_ERS_CHIP) op_o = OP_CHIP;
            end
            default: state_d = SQ_IDLE;
         endcase
         // identify survives only while a sequence is still advancing
         if (state_d == SQ_IDLE) begin
            ident_d = (state_q == SQ_UNL2) && at_first && (wr_data == CMD_IDENTIFY);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         ident_q <= 1'b0;
      end else begin
         state_q <= state_d;
         ident_q <= ident_d;
      end
   end

   assign ident_o = ident_q;
   assign state_o = state_q;

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
   import flash_cmd_pkg::*;
#(
   parameter int PROG_CYC   = 7500,
   parameter int SERASE_CYC = 2500000,
   parameter int CERASE_CYC = 750000000
) (
   input  logic clk,
   input  logic rst_n,
   input  op_t  op_i,
   output logic busy_o
);

   localparam int MAX_AB = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
   localparam int MAX_C  = (MAX_AB > CERASE_CYC) ? MAX_AB : CERASE_CYC;
   localparam int CW     = $clog2(MAX_C + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (op_i)
            OP_PROG: cnt_q <= CW'(PROG_CYC);
            OP_SECT: cnt_q <= CW'(SERASE_CYC);
            OP_CHIP: cnt_q <= CW'(CERASE_CYC);
            default: if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
         endcase
      end
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
   import flash_cmd_pkg::*;
#(
   parameter int SECT_LOG2  = 4,
   parameter int NSECT_LOG2 = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  op_t                             op_i,
   input  logic [SECT_LOG2+NSECT_LOG2-1:0] widx_i,
   input  logic [7:0]                      wdata_i,
   input  logic [SECT_LOG2+NSECT_LOG2-1:0] ridx_i,
   output logic [7:0]                      rdata_o
);

   localparam int ARR_LOG2 = SECT_LOG2 + NSECT_LOG2;
   localparam int DEPTH    = 1 << ARR_LOG2;

   logic [7:0]           cell_q [DEPTH];
   logic [NSECT_LOG2-1:0] wsect;

   assign wsect = widx_i[ARR_LOG2-1:SECT_LOG2];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [7:0] byte_q;
      logic       hit_erase, hit_prog;

      assign hit_erase = (op_i == OP_CHIP) ||
                         ((op_i == OP_SECT) && (wsect == NSECT_LOG2'(i >> SECT_LOG2)));
      assign hit_prog  = (op_i == OP_PROG) && (widx_i == ARR_LOG2'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         byte_q <= ERASED_BYTE;
         else if (hit_erase) byte_q <= ERASED_BYTE;
         else if (hit_prog)  byte_q <= byte_q & wdata_i;
      end

      assign cell_q[i] = byte_q;
   end

   assign rdata_o = cell_q[ridx_i];

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int         ADDR_W     = 18,
   parameter int         SECT_LOG2  = 4,
   parameter int         NSECT_LOG2 = 3,
   parameter int         PROG_CYC   = 7500,
   parameter int         SERASE_CYC = 2500000,
   parameter int         CERASE_CYC = 750000000,
   parameter logic [7:0] MFR_ID     = 8'h40,
   parameter logic [7:0] DEV_ID     = 8'h82
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);

   localparam int ARR_LOG2 = SECT_LOG2 + NSECT_LOG2;
   localparam int ID_OFS_W = 8;

   if (ADDR_W < UNLOCK_W) begin : g_err_aw
      $error("ADDR_W must cover the unlock address bits");
   end
   if (ARR_LOG2 > ADDR_W) begin : g_err_arr
      $error("array larger than address space");
   end
   if (SECT_LOG2 < 1 || NSECT_LOG2 < 1) begin : g_err_geom
      $error("sector geometry parameters must be at least 1");
   end
   if (PROG_CYC < 1 || SERASE_CYC < 1 || CERASE_CYC < 1) begin : g_err_tim
      $error("busy lengths must be at least one cycle");
   end

   op_t           op;
   logic          ident;
   seq_state_t    seq_state;
   logic [7:0]    arr_rdata;
   logic [7:0]    id_byte;
   logic          wr_en;

   assign wr_en = wr_stb & ~busy;

   flash_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .op_o    (op),
      .ident_o (ident),
      .state_o (seq_state)
   );

   flash_busy_timer #(
      .PROG_CYC   (PROG_CYC),
      .SERASE_CYC (SERASE_CYC),
      .CERASE_CYC (CERASE_CYC)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (op),
      .busy_o (busy)
   );

   flash_cell_array #(
      .SECT_LOG2  (SECT_LOG2),
      .NSECT_LOG2 (NSECT_LOG2)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (op),
      .widx_i  (wr_addr[ARR_LOG2-1:0]),
      .wdata_i (wr_data),
      .ridx_i  (rd_addr[ARR_LOG2-1:0]),
      .rdata_o (arr_rdata)
   );

   always_comb begin
      unique case (rd_addr[ID_OFS_W-1:0])
         8'h00:   id_byte = MFR_ID;
         8'h01:   id_byte = DEV_ID;
         default: id_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= ERASED_BYTE;
      else if (busy)  rd_data <= ERASED_BYTE;
      else if (ident) rd_data <= id_byte;
      else            rd_data <= arr_rdata;
   end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
   import flash_cmd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_stb,
   input logic       busy,
   input logic [7:0] rd_data,
   input seq_state_t seq_state,
   input logic       ident
);

   // R4
   busy_rise_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_stb));

   // R4
   busy_rise_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (seq_state == SQ_IDLE));

   // R10
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stb) |=> ($stable(seq_state) && $stable(ident)));

   // R11
   busy_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (rd_data == 8'hFF));

   // R7
   ident_read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ident && !busy) |-> (rd_data == 8'h40 || rd_data == 8'h82 || rd_data == 8'h00));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb    (wr_stb),
   .busy      (busy),
   .rd_data   (rd_data),
   .seq_state (seq_state),
   .ident     (ident)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

   localparam int AW    = 18;
   localparam int SL    = 3;
   localparam int NL    = 2;
   localparam int DEPTH = 1 << (SL + NL);
   localparam int PC    = 5;
   localparam int SC    = 12;
   localparam int CC    = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          busy;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;
   logic [7:0] model [DEPTH];

   always #2 clk = ~clk;

   flash_cmd_decoder #(
      .ADDR_W(AW), .SECT_LOG2(SL), .NSECT_LOG2(NL),
      .PROG_CYC(PC), .SERASE_CYC(SC), .CERASE_CYC(CC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_addr = a;
      @(negedge clk);
      v = rd_data;
   endtask

   task automatic wait_busy(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic prefix(input logic [AW-1:0] hi);
      wr(hi | AW'(18'h05555), 8'hAA);
      wr(hi | AW'(18'h02AAA), 8'h55);
   endtask

   task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d, output int n);
      prefix('0);
      wr(AW'(18'h05555), 8'hA0);
      wr(a, d);
      wait_busy(n);
   endtask

   task automatic sweep(input string req);
      logic [7:0] v;
      for (int i = 0; i < DEPTH; i++) begin
         rd(AW'(i) | (AW'(i % 4) << 10), v);
         check(req, v, model[i]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", busy, 0);
      sweep("R1 erased after reset");

      // R3 R2 R4 program every byte, upper address bits aliased
      for (int i = 0; i < DEPTH; i++) begin
         logic [7:0] d;
         d = 8'((i * 29 + 7) ^ (i << 3));
         program_byte(AW'(i) | (AW'(i % 3) << 12), d, n);
         model[i] = model[i] & d;
         if (i == 0) check("R4 program busy length", n, PC);
      end
      sweep("R2 R3 read after program");

      // R3 reprogram cannot set bits
      program_byte(AW'(3), 8'hF0, n);
      model[3] = model[3] & 8'hF0;
      program_byte(AW'(3), 8'h0F, n);
      model[3] = model[3] & 8'h0F;
      rd(AW'(3), v);
      check("R3 and-only program", v, model[3]);

      // R11 read while program busy
      prefix('0);
      wr(AW'(18'h05555), 8'hA0);
      wr(AW'(20), 8'h00);
      model[20] = 8'h00;
      rd(AW'(20), v);
      check("R11 read during busy", v, 8'hFF);
      wait_busy(n);
      rd(AW'(20), v);
      check("R11 read after busy", v, 8'h00);

      // R7 identify mode
      prefix('0);
      wr(AW'(18'h05555), 8'h90);
      rd(AW'(18'h20100), v);
      check("R7 manufacturer id", v, 8'h40);
      rd(AW'(18'h00301), v);
      check("R7 device id", v, 8'h82);
      rd(AW'(18'h00002), v);
      check("R7 other offset", v, 8'h00);
      // R8 single F0 anywhere
      wr(AW'(18'h01234), 8'hF0);
      rd(AW'(1), v);
      check("R8 lone F0 exits identify", v, model[1]);
      // R8 full F0 sequence
      prefix('0);
      wr(AW'(18'h05555), 8'h90);
      rd(AW'(1), v);
      check("R7 identify again", v, 8'h82);
      prefix('0);
      wr(AW'(18'h05555), 8'hF0);
      rd(AW'(1), v);
      check("R8 sequence F0 exits identify", v, model[1]);

      // R9 mismatch cases
      prefix('0);
      wr(AW'(18'h01234), 8'hA0);
      wr(AW'(5), 8'h00);
      rd(AW'(5), v);
      check("R9 wrong command address", v, model[5]);
      wr(AW'(18'h05555), 8'hAA);
      wr(AW'(18'h02AAB), 8'h55);
      wr(AW'(18'h05555), 8'hA0);
      wr(AW'(6), 8'h00);
      rd(AW'(6), v);
      check("R9 wrong second unlock", v, model[6]);
      prefix('0);
      wr(AW'(18'h05555), 8'h90);
      wr(AW'(18'h05555), 8'hAA);
      rd(AW'(0), v);
      check("R7 identify kept mid sequence", v, 8'h40);
      wr(AW'(18'h00001), 8'h00);
      rd(AW'(0), v);
      check("R9 mismatch exits identify", v, model[0]);

      // R12 high address bits ignored for unlock
      wr(AW'(18'h3D555), 8'hAA);
      wr(AW'(18'h3AAAA), 8'h55);
      wr(AW'(18'h1D555), 8'hA0);
      wr(AW'(7), 8'h00);
      wait_busy(n);
      model[7] = 8'h00;
      rd(AW'(7), v);
      check("R12 unlock with high bits", v, 8'h00);

      // R5 sector erase of sector 1 via aliased address
      prefix('0);
      wr(AW'(18'h05555), 8'h80);
      prefix('0);
      wr(AW'(18'h0010A), 8'h30);
      wait_busy(n);
      check("R4 sector erase busy length", n, SC);
      for (int i = 8; i < 16; i++) model[i] = 8'hFF;
      sweep("R5 sector erase");

      // R6 chip erase
      prefix('0);
      wr(AW'(18'h05555), 8'h80);
      prefix('0);
      wr(AW'(18'h05555), 8'h10);
      wait_busy(n);
      check("R4 chip erase busy length", n, CC);
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      sweep("R6 chip erase");

      // R10 writes during erase busy are ignored
      prefix('0);
      wr(AW'(18'h05555), 8'h80);
      prefix('0);
      wr(AW'(18'h05555), 8'h10);
      check("R10 busy at start", busy, 1);
      prefix('0);
      wr(AW'(18'h05555), 8'hA0);
      wr(AW'(2), 8'h00);
      wait_busy(n);
      wr(AW'(2), 8'h00);
      rd(AW'(2), v);
      check("R10 program during erase ignored", v, 8'hFF);
      sweep("R10 array after busy writes");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule